// File: doc/BRIEF.md
# Synthesizer Divider Configuration Loader

This block is the digital configuration front end of a frequency synthesizer. It holds the active feedback divide value (9-bit weighted binary), the 2-bit output divide code and a 2-bit test-select code. These settings can be written in two ways. The first is a set of parallel pins qualified by an active-low strobe: the pins pass through while the strobe is low and are captured when it rises. The second is a three-wire serial port made of a serial clock, a data line and a load line. The serial port has a separate transfer edge, a hold edge, and a flow-through mode in which every serial clock updates the active settings.

A single-bit monitor output is driven from the test-select code. It can carry a constant low, an echo of the serial data line, the feedback divider output or the synthesized clock. All asynchronous inputs are brought into one fast system clock through synchronizers, and their edges are found inside the block. A combinational flag marks a feedback divide value outside the range that locks with a 25 MHz reference. The master reset input clears only the downstream divider path. A separate power-on reset clears the configuration.

Top module: `synth_cfg_loader`

## Requirements
- R1: While the synchronized strobe `pload_n_i` is low, `m_o` and `n_o` equal `par_m_i` and `par_n_i` as sampled three clock edges earlier.
- R2: A rising edge of `pload_n_i` captures the pin values. `m_o` and `n_o` then hold against later pin changes until the strobe goes low again or a serial transfer occurs.
- R3: While the strobe is high, each rising edge of `sclk_i` shifts `sdata_i` into a 14-bit shift register. While `sload_i` is low, shifting leaves `m_o`, `n_o` and `t_o` unchanged.
- R4: The serial frame is sent first bit first in this order: test code bit 1, test code bit 0, one discarded slot, output code bit 1, output code bit 0, then feedback value bit 8 down to bit 0.
- R5: A rising edge of `sload_i` (strobe high) loads the decoded shift register into `m_o`, `n_o` and `t_o`. The falling edge of `sload_i` leaves them unchanged.
- R6: While `sload_i` is high, each rising edge of `sclk_i` updates `m_o`, `n_o` and `t_o` to the new shift register contents.
- R7: With the strobe high, `test_o` follows `t_o`: 00 gives low, 01 gives `sdata_i`, 10 gives `mdiv_fb_i`, 11 gives `fout_i`. The selected source appears three edges after it changes.
- R8: `test_o` is low in parallel mode (synchronized strobe low).
- R9: `m_out_of_range_o` is high exactly when `m_o` is below 10 or above 28.
- R10: `mrst_i` leaves `m_o`, `n_o` and `t_o` unchanged. While `mrst_i` is high, `test_o` is low in test codes 10 and 11.
- R11: Power-on reset `rst` clears `m_o`, `n_o`, `t_o`, `test_o` and the shift register. Synchronizers read the strobe as high and all other inputs as low, so no capture follows reset release.
- R12: `t_o` does not change in parallel mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| mrst_i | input | 1 | Master reset for the divider path (asynchronous) |
| pload_n_i | input | 1 | Active-low parallel load strobe |
| par_m_i | input | 9 | Parallel feedback divide value |
| par_n_i | input | 2 | Parallel output divide code |
| sclk_i | input | 1 | Serial clock |
| sdata_i | input | 1 | Serial data |
| sload_i | input | 1 | Serial load |
| mdiv_fb_i | input | 1 | Feedback divider output for monitoring |
| fout_i | input | 1 | Synthesized clock for monitoring |
| m_o | output | 9 | Active feedback divide value |
| n_o | output | 2 | Active output divide code (00 ÷1, 01 ÷2, 10 ÷4, 11 ÷8) |
| t_o | output | 2 | Active test-select code |
| test_o | output | 1 | Registered test monitor output |
| m_out_of_range_o | output | 1 | Feedback value outside 10 to 28 |

## Verification
Every asynchronous input passes two synchronizer flops, and every result register sits one flop further on. So `m_o`, `n_o`, `t_o` and `test_o` react on the third rising edge after an input change, and the range flag reacts in the same cycle as `m_o`. The bench keeps a behavioural model that delays its sampled inputs through a three-entry queue and compares every output on each falling edge. Directed checks wait at least three edges after each stimulus step before sampling. Serial bits are held for three cycles on each side of every serial clock edge, so no two events fall in the same synchronized cycle.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  // width of the test-select code; the monitor mux decodes exactly four sources
  localparam int TSEL_W = 2;

  typedef enum logic [TSEL_W-1:0] {
    TSEL_LOW  = 2'b00,
    TSEL_ECHO = 2'b01,
    TSEL_MFB  = 2'b10,
    TSEL_FOUT = 2'b11
  } tsel_e;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[0] <= RST_VAL;
        else     stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= RST_VAL;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cfg_edge.sv
module cfg_edge #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= RST_VAL;
    else     prev_q <= d;
  end

  assign rise = d & ~prev_q;
endmodule

// File: rtl/cfg_shift.sv
module cfg_shift #(
  parameter int M_W    = 9,
  parameter int N_W    = 2,
  parameter int T_W    = 2,
  parameter int NULL_W = 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           shift_en,
  input  logic           din,
  output logic [M_W-1:0] m_nx,
  output logic [N_W-1:0] n_nx,
  output logic [T_W-1:0] t_nx
);
  localparam int FRAME_W = T_W + NULL_W + N_W + M_W;

  logic [FRAME_W-1:0] sr_q;
  logic [FRAME_W-1:0] sr_d;

  // first bit sent ends up at the top of the register
  assign sr_d = shift_en ? {sr_q[FRAME_W-2:0], din} : sr_q;

  always_ff @(posedge clk) begin
    if (rst) sr_q <= '0;
    else     sr_q <= sr_d;
  end

  assign m_nx = sr_d[M_W-1:0];
  assign n_nx = sr_d[M_W +: N_W];
  assign t_nx = sr_d[FRAME_W-1 -: T_W];
endmodule

// File: rtl/cfg_test_mux.sv
module cfg_test_mux
  import cfg_loader_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              par_mode,
  input  logic [TSEL_W-1:0] tsel,
  input  logic              div_clr,
  input  logic              echo,
  input  logic              mfb,
  input  logic              fout,
  output logic              test_q
);
  always_ff @(posedge clk) begin
    if (rst || par_mode) begin
      test_q <= 1'b0;
    end else begin
      case (tsel_e'(tsel))
        TSEL_ECHO: test_q <= echo;
        TSEL_MFB:  test_q <= mfb & ~div_clr;
        TSEL_FOUT: test_q <= fout & ~div_clr;
        default:   test_q <= 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/synth_cfg_loader.sv
module synth_cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int M_W         = 9,
  parameter int N_W         = 2,
  parameter int NULL_W      = 1,
  parameter int SYNC_STAGES = 2,
  parameter int M_MIN       = 10,
  parameter int M_MAX       = 28
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mrst_i,
  input  logic              pload_n_i,
  input  logic [M_W-1:0]    par_m_i,
  input  logic [N_W-1:0]    par_n_i,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              sload_i,
  input  logic              mdiv_fb_i,
  input  logic              fout_i,
  output logic [M_W-1:0]    m_o,
  output logic [N_W-1:0]    n_o,
  output logic [TSEL_W-1:0] t_o,
  output logic              test_o,
  output logic              m_out_of_range_o
);
  localparam int IN_W = M_W + N_W + 7;
  localparam logic [IN_W-1:0] SYNC_RST = {1'b1, {(IN_W-1){1'b0}}};
  localparam logic [M_W-1:0]  M_LO = M_W'(M_MIN);
  localparam logic [M_W-1:0]  M_HI = M_W'(M_MAX);

  logic [IN_W-1:0] raw, syn;
  logic            s_pl, s_sclk, s_sd, s_sl, s_md, s_fo, s_mr;
  logic [M_W-1:0]  s_m;
  logic [N_W-1:0]  s_n;
  logic [2:0]      rise;
  logic            pl_rise, sclk_rise, sl_rise;
  logic [M_W-1:0]  m_nx;
  logic [N_W-1:0]  n_nx;
  logic [TSEL_W-1:0] t_nx;
  logic            par_upd, ser_upd;
  logic [M_W-1:0]  m_q;
  logic [N_W-1:0]  n_q;
  logic [TSEL_W-1:0] t_q;

  assign raw = {pload_n_i, par_m_i, par_n_i, sclk_i, sdata_i, sload_i,
                mdiv_fb_i, fout_i, mrst_i};

  cfg_sync #(.W(IN_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst(rst), .d(raw), .q(syn)
  );

  assign s_pl   = syn[IN_W-1];
  assign s_m    = syn[IN_W-2 -: M_W];
  assign s_n    = syn[6 +: N_W];
  assign s_sclk = syn[5];
  assign s_sd   = syn[4];
  assign s_sl   = syn[3];
  assign s_md   = syn[2];
  assign s_fo   = syn[1];
  assign s_mr   = syn[0];

  cfg_edge #(.W(3), .RST_VAL(3'b100)) u_edge (
    .clk(clk), .rst(rst), .d({s_pl, s_sclk, s_sl}), .rise(rise)
  );

  assign pl_rise   = rise[2];
  assign sclk_rise = rise[1];
  assign sl_rise   = rise[0];

  cfg_shift #(.M_W(M_W), .N_W(N_W), .T_W(TSEL_W), .NULL_W(NULL_W)) u_shift (
    .clk(clk), .rst(rst), .shift_en(s_pl & sclk_rise), .din(s_sd),
    .m_nx(m_nx), .n_nx(n_nx), .t_nx(t_nx)
  );

  // parallel pins win over serial activity in the cycle the strobe rises
  assign par_upd = ~s_pl | pl_rise;
  assign ser_upd = s_pl & ~pl_rise & (sl_rise | (s_sl & sclk_rise));

  always_ff @(posedge clk) begin
    if (rst) begin
      m_q <= '0;
      n_q <= '0;
      t_q <= '0;
    end else if (par_upd) begin
      m_q <= s_m;
      n_q <= s_n;
    end else if (ser_upd) begin
      m_q <= m_nx;
      n_q <= n_nx;
      t_q <= t_nx;
    end
  end

  cfg_test_mux u_tmux (
    .clk(clk), .rst(rst), .par_mode(~s_pl), .tsel(t_q), .div_clr(s_mr),
    .echo(s_sd), .mfb(s_md), .fout(s_fo), .test_q(test_o)
  );

  assign m_o = m_q;
  assign n_o = n_q;
  assign t_o = t_q;
  assign m_out_of_range_o = (m_q < M_LO) || (m_q > M_HI);
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk #(
  parameter int M_W = 9,
  parameter int N_W = 2
) (
  input logic           clk,
  input logic           rst,
  input logic           pload_n_i,
  input logic           test_o,
  input logic [M_W-1:0] m_o,
  input logic [N_W-1:0] n_o,
  input logic [1:0]     t_o,
  input logic           s_pl,
  input logic           s_sl,
  input logic [M_W-1:0] s_m,
  input logic           pl_rise,
  input logic           sclk_rise,
  input logic           sl_rise,
  input logic [M_W-1:0] m_nx
);
  p_follow_pins_r1: assert property (@(posedge clk) disable iff (rst)
    !s_pl |=> (m_o == $past(s_m)));

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (s_pl && !pl_rise && !sclk_rise && !sl_rise) |=> $stable({m_o, n_o, t_o}));

  p_transfer_r5: assert property (@(posedge clk) disable iff (rst)
    (s_pl && !pl_rise && sl_rise) |=> (m_o == $past(m_nx)));

  p_flow_r6: assert property (@(posedge clk) disable iff (rst)
    (s_pl && !pl_rise && s_sl && sclk_rise) |=> (m_o == $past(m_nx)));

  p_test_low_par_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(pload_n_i, 3) && !$past(pload_n_i, 2)) |-> !test_o);

  p_t_kept_par_r12: assert property (@(posedge clk) disable iff (rst)
    !s_pl |=> $stable(t_o));
endmodule

bind synth_cfg_loader cfg_loader_chk #(.M_W(M_W), .N_W(N_W)) u_chk (
  .clk(clk), .rst(rst), .pload_n_i(pload_n_i), .test_o(test_o),
  .m_o(m_o), .n_o(n_o), .t_o(t_o), .s_pl(s_pl), .s_sl(s_sl), .s_m(s_m),
  .pl_rise(pl_rise), .sclk_rise(sclk_rise), .sl_rise(sl_rise), .m_nx(m_nx)
);

// File: tb/test_synth_cfg_loader.sv
`timescale 1ns/1ps
module test_synth_cfg_loader;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mrst = 0, pload_n = 1, sclk = 0, sdata = 0, sload = 0, mdiv = 0, fout = 0;
  logic [8:0] par_m = '0;
  logic [1:0] par_n = '0;
  logic [8:0] m_o;
  logic [1:0] n_o, t_o;
  logic test_o, flag_o;

  always #5 clk = ~clk;

  synth_cfg_loader i_synth_cfg_loader (
    .clk(clk), .rst(rst), .mrst_i(mrst), .pload_n_i(pload_n), .par_m_i(par_m),
    .par_n_i(par_n), .sclk_i(sclk), .sdata_i(sdata), .sload_i(sload),
    .mdiv_fb_i(mdiv), .fout_i(fout), .m_o(m_o), .n_o(n_o), .t_o(t_o),
    .test_o(test_o), .m_out_of_range_o(flag_o)
  );

  typedef struct packed {
    logic       pl;
    logic [8:0] pm;
    logic [1:0] pn;
    logic       sc, sd, sl, md, fo, mr;
  } smp_t;

  localparam smp_t RV = '{pl: 1'b1, pm: '0, pn: '0, default: 1'b0};

  int vectors = 0;
  int miscompares = 0;
  string phase = "R11";

  // behavioural reference
  smp_t hist[$];
  logic [8:0]  em = '0;
  logic [1:0]  en = '0, et = '0;
  logic        etest = 1'b0;
  logic [13:0] esr = '0;
  logic [13:0] sh = '0;

  always @(posedge clk) begin
    smp_t cur, prv, smp;
    logic plr, scr, slr, nt;
    logic [13:0] nsr;
    smp = {pload_n, par_m, par_n, sclk, sdata, sload, mdiv, fout, mrst};
    if (rst) begin
      hist = {RV, RV, RV};
      em = '0; en = '0; et = '0; etest = 0; esr = '0;
    end else begin
      cur = hist[1];
      prv = hist[0];
      plr = cur.pl && !prv.pl;
      scr = cur.sc && !prv.sc;
      slr = cur.sl && !prv.sl;
      nsr = (cur.pl && scr) ? {esr[12:0], cur.sd} : esr;
      if (!cur.pl) nt = 0;
      else case (et)
        2'd1:    nt = cur.sd;
        2'd2:    nt = cur.md && !cur.mr;
        2'd3:    nt = cur.fo && !cur.mr;
        default: nt = 0;
      endcase
      etest = nt;
      if (!cur.pl || plr) begin
        em = cur.pm; en = cur.pn;
      end else if (slr || (cur.sl && scr)) begin
        et = nsr[13:12]; en = nsr[10:9]; em = nsr[8:0];
      end
      esr = nsr;
      void'(hist.pop_front());
      hist.push_back(smp);
    end
  end

  always @(negedge clk) begin
    logic ef;
    ef = (em < 9'd10) || (em > 9'd28);
    vectors++;
    if (m_o !== em || n_o !== en || t_o !== et || test_o !== etest || flag_o !== ef) begin
      miscompares++;
      $display("FAIL %s model: m=%0d/%0d n=%0d/%0d t=%0d/%0d test=%b/%b flag=%b/%b (actual/expected)",
               phase, m_o, em, n_o, en, t_o, et, test_o, etest, flag_o, ef);
    end
  end

  task automatic chk(input string r, input string what, input int got, input int exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", r, what, got, exp);
    end
  endtask

  task automatic waitn(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic sbit(input logic b);
    sdata = b; waitn(3);
    sclk = 1;  sh = {sh[12:0], b}; waitn(3);
    sclk = 0;  waitn(3);
  endtask

  task automatic send_frame(input logic [1:0] t, input logic [1:0] n, input logic [8:0] m);
    logic [13:0] f;
    f = {t, 1'b0, n, m};
    for (int i = 13; i >= 0; i--) sbit(f[i]);
  endtask

  task automatic pulse_load();
    sload = 1; waitn(4);
    sload = 0; waitn(4);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    waitn(5);
    // R11: reset state
    chk("R11", "m after reset", m_o, 0);
    chk("R11", "test after reset", test_o, 0);
    chk("R9", "flag with m=0", flag_o, 1);
    rst = 0; waitn(5);
    chk("R11", "no capture at reset release", m_o, 0);

    // R1 / R9: parallel pass-through and range boundaries
    phase = "R1";
    pload_n = 0; par_m = 9'd20; par_n = 2'd1; waitn(4);
    chk("R1", "m follows pins", m_o, 20);
    chk("R1", "n follows pins", n_o, 1);
    phase = "R9";
    par_m = 9'd9;  waitn(4); chk("R9", "flag m=9", flag_o, 1);
    par_m = 9'd10; waitn(4); chk("R9", "flag m=10", flag_o, 0);
    par_m = 9'd28; waitn(4); chk("R9", "flag m=28", flag_o, 0);
    par_m = 9'd29; waitn(4); chk("R9", "flag m=29", flag_o, 1);
    par_m = 9'd300; waitn(4); chk("R9", "flag m=300", flag_o, 1);

    // R2: capture on strobe rise, hold afterwards
    phase = "R2";
    par_m = 9'd17; par_n = 2'd2; waitn(4);
    pload_n = 1; waitn(4);
    par_m = 9'd300; par_n = 2'd0; waitn(6);
    chk("R2", "m held after capture", m_o, 17);
    chk("R2", "n held after capture", n_o, 2);

    // R3 / R4 / R5: serial frame, transfer, latch
    phase = "R3";
    send_frame(2'b01, 2'b11, 9'd25);
    chk("R3", "m unchanged while shifting", m_o, 17);
    phase = "R5";
    sload = 1; waitn(4);
    chk("R4", "m from frame", m_o, 25);
    chk("R4", "n from frame", n_o, 3);
    chk("R4", "t from frame", t_o, 1);
    sload = 0; waitn(4);
    chk("R5", "m after sload fall", m_o, 25);

    // R7: echo of serial data (sclk idle, no shift)
    phase = "R7";
    sdata = 1; waitn(4); chk("R7", "echo high", test_o, 1);
    sdata = 0; waitn(4); chk("R7", "echo low", test_o, 0);

    // R7 / R10: feedback monitor and master reset
    send_frame(2'b10, 2'b00, 9'd10); pulse_load();
    chk("R2", "serial event overrides parallel hold", m_o, 10);
    mdiv = 1; waitn(4); chk("R7", "mfb monitor high", test_o, 1);
    phase = "R10";
    mrst = 1; waitn(4);
    chk("R10", "test low under master reset", test_o, 0);
    chk("R10", "m kept under master reset", m_o, 10);
    chk("R10", "t kept under master reset", t_o, 2);
    mrst = 0; waitn(4); chk("R10", "monitor back", test_o, 1);
    mdiv = 0; waitn(4); chk("R7", "mfb monitor low", test_o, 0);

    // R7: synthesized clock monitor, then code 00
    phase = "R7";
    send_frame(2'b11, 2'b01, 9'd28); pulse_load();
    fout = 1; waitn(4); chk("R7", "fout monitor high", test_o, 1);
    mrst = 1; waitn(4); chk("R10", "fout gated by master reset", test_o, 0);
    mrst = 0; waitn(4);

    // R8 / R12: parallel mode forces TEST low, keeps t
    phase = "R8";
    pload_n = 0; par_m = 9'd12; waitn(4);
    chk("R8", "test low in parallel mode", test_o, 0);
    chk("R12", "t kept in parallel mode", t_o, 3);
    sdata = 1; sclk = 1; waitn(4); sclk = 0; sdata = 0; waitn(4);
    chk("R12", "t kept with serial clocks in parallel mode", t_o, 3);
    pload_n = 1; waitn(4);
    fout = 0; waitn(4);
    chk("R7", "fout monitor low", test_o, 0);

    // R6: flow-through while sload is held high
    phase = "R6";
    sload = 1; waitn(4);
    for (int i = 0; i < 14; i++) begin
      sbit(((i * 5) % 3) == 0);
      chk("R6", "m follows shift register", m_o, sh[8:0]);
      chk("R6", "t follows shift register", t_o, sh[13:12]);
    end
    sload = 0; waitn(4);
    chk("R5", "m held after flow-through", m_o, sh[8:0]);

    // R3: shifting with sload low after flow-through leaves registers
    phase = "R3";
    begin
      logic [8:0] keep;
      keep = m_o;
      sbit(1); sbit(0); sbit(1);
      chk("R3", "m unchanged by extra shifts", m_o, keep);
    end
    send_frame(2'b00, 2'b10, 9'd5); pulse_load();
    chk("R7", "code 00 drives low", test_o, 0);
    chk("R9", "flag after serial m=5", flag_o, 1);
    waitn(4);
    finish_run();
  end
endmodule